// File: doc/BRIEF.md
# Dual-Clock Stream FIFO with Programmable Level Flags

This block moves 36-bit words from a producer running on one clock to a consumer running on another. The two clocks run freely and have no fixed relation. They may be asynchronous or they may be the same net. Storage is a 64-entry array.

The write port reports full and almost-full in the producer's clock domain. The read port reports empty and almost-empty in the consumer's clock domain. Each flag is computed from a pointer that crossed over from the other domain in Gray code through two flip-flops.

Both data ports use a valid/ready handshake:
- **Write side:** a word is taken on a rising edge of `clk_a` when `wr_valid` and `wr_ready` are both high. `wr_ready` is low exactly while the FIFO reports full. A producer that holds `wr_valid` high against a low `wr_ready` is held back, and its word is not stored.
- **Read side:** `rd_valid` is high whenever the FIFO is not empty, and `rd_data` then shows the oldest word. That word is consumed on a rising edge of `clk_b` when `rd_ready` is also high.

The two almost-flag levels are loaded from plain configuration pins. A reset returns both levels to 8.

Top module: `xclk_stream_fifo`

## Requirements
- R1: While `rst_n` is low and after it is released with no traffic, `empty` and `almost_empty` are 1, `full` and `almost_full` are 0, `wr_ready` is 1 and `rd_valid` is 0.
- R2: Words leave on `rd_data` in the order they were accepted, with all 36 bits unchanged.
- R3: A write presented while `full` is 1 (`wr_ready` is 0) is not stored. The stored words and the flags stay as they were.
- R4: A read requested while `empty` is 1 (`rd_valid` is 0) does not move the read position. The next word written is the next word read.
- R5: `full` becomes 1 once 64 words are held, and `wr_ready` is then 0.
- R6: `empty` becomes 1 once every accepted word has been read, and `rd_valid` is then 0.
- R7: `almost_empty` is 1 when the number of stored words is at or below the empty level, and 0 when it is above it.
- R8: `almost_full` is 1 when the number of free entries (64 minus stored) is at or below the full level, and 0 when it is above it.
- R9: After reset, both levels are 8 until new levels are loaded.
- R10: A clock edge with `cfg_load` high loads `cfg_ae_lvl` as the empty level on `clk_b` and `cfg_af_lvl` as the full level on `clk_a`.
- R11: Each pointer sent across the clock boundary changes by at most one bit per clock of its own domain.
- R12: A word is transferred on a port only on a rising edge of that port's clock where both valid and ready are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock, free running |
| clk_b | input | 1 | Read-side clock, free running |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| cfg_load | input | 1 | Loads the level inputs on each side's clock edge |
| cfg_ae_lvl | input | 6 | Almost-empty level in words |
| cfg_af_lvl | input | 6 | Almost-full level in free entries |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | FIFO can accept a word |
| wr_data | input | 36 | Write word |
| full | output | 1 | 64 words held (`clk_a` domain) |
| almost_full | output | 1 | Free entries at or below the full level (`clk_a` domain) |
| rd_valid | output | 1 | `rd_data` holds a word |
| rd_ready | input | 1 | Consumer takes the word |
| rd_data | output | 36 | Oldest stored word |
| empty | output | 1 | No words held (`clk_b` domain) |
| almost_empty | output | 1 | Stored words at or below the empty level (`clk_b` domain) |

## Verification
The hardest condition to reach is the pointer wrap with a full array and a producer still pushing. The write pointer must then sit exactly one lap ahead of the synchronized read pointer, and extra writes must be refused without corrupting the entry at the read position. The stimulus gets there by filling all 64 entries. It then holds `wr_valid` high with marker data for several cycles and drains the whole array against a model queue, so any stored marker or lost word shows up as a mismatch. The threshold edges are reached by writing to one word below each level, letting the flags settle across both domains, and then stepping one word across the level.

// File: rtl/xfifo_pkg.sv
package xfifo_pkg;
  localparam int GW = 16;

  function automatic logic [GW-1:0] to_gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] from_gray(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    for (int i = 0; i < GW; i++) b[i] = ^(g >> i);
    return b;
  endfunction
endpackage

// File: rtl/xfifo_sync2.sv
module xfifo_sync2 #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/xfifo_ram.sv
module xfifo_ram #(
  parameter int DW = 36,
  parameter int AW = 6
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/xfifo_wside.sv
module xfifo_wside
  import xfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DEF_LVL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_lvl,
  input  logic          push_req,
  input  logic [AW:0]   rgray_s,
  output logic          push,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          full,
  output logic          afull
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  logic [PW-1:0] wbin, wbin_nx, wgray_nx, rbin_s, used, spare;
  logic [AW-1:0] lvl;

  assign push     = push_req & ~full;
  assign wbin_nx  = wbin + PW'(push);
  assign wgray_nx = PW'(to_gray(GW'(wbin_nx)));
  assign rbin_s   = PW'(from_gray(GW'(rgray_s)));
  assign used     = wbin_nx - rbin_s;
  assign spare    = PW'(DEPTH) - used;
  assign waddr    = wbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
      full  <= 1'b0;
      afull <= 1'b0;
      lvl   <= AW'(DEF_LVL);
    end else begin
      wbin  <= wbin_nx;
      wgray <= wgray_nx;
      full  <= (wgray_nx == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
      afull <= (spare <= {1'b0, lvl});
      if (cfg_load) lvl <= cfg_lvl;
    end
  end

  p_full_refuses_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push_req) |=> $stable(wbin));
  p_gray_step_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));
  p_full_in_af_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> afull);
endmodule

// File: rtl/xfifo_rside.sv
module xfifo_rside
  import xfifo_pkg::*;
#(
  parameter int AW = 6,
  parameter int DEF_LVL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_lvl,
  input  logic          pop_req,
  input  logic [AW:0]   wgray_s,
  output logic          pop,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic          empty,
  output logic          aempty
);
  localparam int PW = AW + 1;

  logic [PW-1:0] rbin, rbin_nx, rgray_nx, wbin_s, held;
  logic [AW-1:0] lvl;

  assign pop      = pop_req & ~empty;
  assign rbin_nx  = rbin + PW'(pop);
  assign rgray_nx = PW'(to_gray(GW'(rbin_nx)));
  assign wbin_s   = PW'(from_gray(GW'(wgray_s)));
  assign held     = wbin_s - rbin_nx;
  assign raddr    = rbin[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin   <= '0;
      rgray  <= '0;
      empty  <= 1'b1;
      aempty <= 1'b1;
      lvl    <= AW'(DEF_LVL);
    end else begin
      rbin   <= rbin_nx;
      rgray  <= rgray_nx;
      empty  <= (rgray_nx == wgray_s);
      aempty <= (held <= {1'b0, lvl});
      if (cfg_load) lvl <= cfg_lvl;
    end
  end

  p_empty_refuses_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop_req) |=> $stable(rbin));
  p_gray_step_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(rgray ^ $past(rgray)) <= 1));
  p_empty_in_ae_r7: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> aempty);
endmodule

// File: rtl/xclk_stream_fifo.sv
module xclk_stream_fifo #(
  parameter int DW = 36,
  parameter int AW = 6,
  parameter int DEF_LVL = 8
) (
  input  logic          clk_a,
  input  logic          clk_b,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_ae_lvl,
  input  logic [AW-1:0] cfg_af_lvl,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [DW-1:0] wr_data,
  output logic          full,
  output logic          almost_full,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [DW-1:0] rd_data,
  output logic          empty,
  output logic          almost_empty
);
  localparam int PW = AW + 1;

  logic          push, pop;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wgray_s, rgray_s;

  xfifo_wside #(.AW(AW), .DEF_LVL(DEF_LVL)) u_wside (
    .clk(clk_a), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lvl(cfg_af_lvl),
    .push_req(wr_valid), .rgray_s(rgray_s), .push(push), .waddr(waddr),
    .wgray(wgray), .full(full), .afull(almost_full)
  );

  xfifo_rside #(.AW(AW), .DEF_LVL(DEF_LVL)) u_rside (
    .clk(clk_b), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lvl(cfg_ae_lvl),
    .pop_req(rd_ready), .wgray_s(wgray_s), .pop(pop), .raddr(raddr),
    .rgray(rgray), .empty(empty), .aempty(almost_empty)
  );

  xfifo_sync2 #(.W(PW)) u_w2r (.clk(clk_b), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  xfifo_sync2 #(.W(PW)) u_r2w (.clk(clk_a), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  xfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(clk_a), .we(push), .waddr(waddr), .wdata(wr_data),
    .raddr(raddr), .rdata(rd_data)
  );

  assign wr_ready = ~full;
  assign rd_valid = ~empty;

  p_push_handshake_r12: assert property (@(posedge clk_a) disable iff (!rst_n)
    push |-> (wr_valid && wr_ready));
  p_pop_handshake_r12: assert property (@(posedge clk_b) disable iff (!rst_n)
    pop |-> (rd_valid && rd_ready));
endmodule

// File: tb/test_xclk_stream_fifo.sv
module test_xclk_stream_fifo;
  logic        clk_a = 0, clk_b = 0, rst_n = 0;
  logic        cfg_load = 0;
  logic [5:0]  cfg_ae_lvl = '0, cfg_af_lvl = '0;
  logic        wr_valid = 0, rd_ready = 0;
  logic [35:0] wr_data = '0;
  logic        wr_ready, full, almost_full, rd_valid, empty, almost_empty;
  logic [35:0] rd_data;

  int n_chk = 0, n_bad = 0, seq = 0;
  logic [35:0] model[$];

  always #4 clk_a = ~clk_a;
  always #5.5 clk_b = ~clk_b;

  xclk_stream_fifo i_xclk_stream_fifo (
    .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_ae_lvl(cfg_ae_lvl), .cfg_af_lvl(cfg_af_lvl),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .full(full), .almost_full(almost_full),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .empty(empty), .almost_empty(almost_empty)
  );

  task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(posedge clk_a);
    repeat (6) @(posedge clk_b);
    @(negedge clk_a);
  endtask

  task automatic do_reset();
    rst_n = 0; wr_valid = 0; rd_ready = 0; cfg_load = 0;
    model.delete();
    repeat (3) @(posedge clk_b);
    @(negedge clk_a); rst_n = 1;
    settle();
  endtask

  function automatic logic [35:0] pattern(input int k);
    return {4'h9 ^ 4'(k), 32'(k) * 32'h0101_0307 ^ 32'hA5C3_0F1E};
  endfunction

  task automatic push_one();
    logic [35:0] d;
    d = pattern(seq); seq++;
    @(negedge clk_a);
    chk("R12 wr_ready before push", {35'd0, wr_ready}, 36'd1);
    wr_valid = 1; wr_data = d;
    @(posedge clk_a);
    model.push_back(d);
    @(negedge clk_a);
    wr_valid = 0;
  endtask

  task automatic pop_one();
    logic [35:0] e;
    e = model.pop_front();
    @(negedge clk_b);
    chk("R12 rd_valid before pop", {35'd0, rd_valid}, 36'd1);
    chk("R2 read order/data", rd_data, e);
    rd_ready = 1;
    @(posedge clk_b);
    @(negedge clk_b);
    rd_ready = 0;
  endtask

  task automatic t_reset_state();
    rst_n = 0;
    repeat (2) @(posedge clk_a);
    @(negedge clk_a);
    chk("R1 empty in reset", {35'd0, empty}, 36'd1);
    chk("R1 full in reset", {35'd0, full}, 36'd0);
    do_reset();
    chk("R1 empty", {35'd0, empty}, 36'd1);
    chk("R1 almost_empty", {35'd0, almost_empty}, 36'd1);
    chk("R1 full", {35'd0, full}, 36'd0);
    chk("R1 almost_full", {35'd0, almost_full}, 36'd0);
    chk("R1 wr_ready", {35'd0, wr_ready}, 36'd1);
    chk("R1 rd_valid", {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_default_levels();
    do_reset();
    repeat (8) push_one();
    settle();
    chk("R9 R7 ae at 8 words", {35'd0, almost_empty}, 36'd1);
    chk("R6 not empty", {35'd0, empty}, 36'd0);
    push_one(); settle();
    chk("R9 R7 ae off at 9 words", {35'd0, almost_empty}, 36'd0);
    repeat (46) push_one(); settle();
    chk("R9 R8 af off at 9 free", {35'd0, almost_full}, 36'd0);
    push_one(); settle();
    chk("R9 R8 af on at 8 free", {35'd0, almost_full}, 36'd1);
    chk("R5 not full at 56", {35'd0, full}, 36'd0);
    repeat (47) pop_one(); settle();
    chk("R7 ae off at 9 words", {35'd0, almost_empty}, 36'd0);
    chk("R8 af off after drain", {35'd0, almost_full}, 36'd0);
    pop_one(); settle();
    chk("R7 ae on at 8 words", {35'd0, almost_empty}, 36'd1);
    while (model.size() > 0) pop_one();
    settle();
    chk("R6 empty after drain", {35'd0, empty}, 36'd1);
  endtask

  task automatic t_overflow();
    do_reset();
    repeat (64) push_one(); settle();
    chk("R5 full at 64", {35'd0, full}, 36'd1);
    chk("R5 wr_ready low", {35'd0, wr_ready}, 36'd0);
    @(negedge clk_a);
    wr_valid = 1; wr_data = 36'hDEAD_BEEF_F;
    repeat (5) @(posedge clk_a);
    @(negedge clk_a); wr_valid = 0;
    settle();
    chk("R3 still full", {35'd0, full}, 36'd1);
    chk("R3 af held", {35'd0, almost_full}, 36'd1);
    while (model.size() > 0) pop_one();
    settle();
    chk("R3 R6 empty after 64 reads", {35'd0, empty}, 36'd1);
    chk("R3 no extra word", {35'd0, rd_valid}, 36'd0);
  endtask

  task automatic t_underflow();
    do_reset();
    push_one(); push_one(); settle();
    pop_one(); pop_one();
    @(negedge clk_b);
    rd_ready = 1;
    repeat (5) @(posedge clk_b);
    @(negedge clk_b); rd_ready = 0;
    settle();
    chk("R4 empty held", {35'd0, empty}, 36'd1);
    chk("R4 rd_valid low", {35'd0, rd_valid}, 36'd0);
    push_one(); settle();
    pop_one(); settle();
    chk("R4 R6 empty again", {35'd0, empty}, 36'd1);
  endtask

  task automatic t_program_levels();
    do_reset();
    @(negedge clk_a);
    cfg_ae_lvl = 6'd3; cfg_af_lvl = 6'd20; cfg_load = 1;
    repeat (3) @(posedge clk_b);
    @(negedge clk_a); cfg_load = 0;
    cfg_ae_lvl = 6'd60; cfg_af_lvl = 6'd60;
    repeat (3) push_one(); settle();
    chk("R10 R7 ae on at 3", {35'd0, almost_empty}, 36'd1);
    push_one(); settle();
    chk("R10 R7 ae off at 4", {35'd0, almost_empty}, 36'd0);
    repeat (39) push_one(); settle();
    chk("R10 R8 af off at 21 free", {35'd0, almost_full}, 36'd0);
    push_one(); settle();
    chk("R10 R8 af on at 20 free", {35'd0, almost_full}, 36'd1);
    while (model.size() > 0) pop_one();
    settle();
    chk("R6 empty at end", {35'd0, empty}, 36'd1);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    t_reset_state();
    t_default_levels();
    t_overflow();
    t_underflow();
    t_program_levels();
    finish_run();
  end
endmodule